// File: doc/BRIEF.md
# Microcoded Processor Datapath Slice

This block is the 16-bit data path of a small microprogrammed processor, steered entirely by a control word presented every clock cycle. An external sequencer supplies the fields: which operand feeds each ALU input, which ALU function runs, whether the main path carries the ALU result or the word on the external bus, and which storage elements capture that path at the clock edge. The block holds no sequencing, bus protocol or instruction decode of its own.

The ALU A operand comes from a 16-entry scratch pad, whose lower eight words serve as the general registers (word 7 is the program counter) and whose upper eight words are temporaries for the microprogram. Word 15 conventionally holds the console's load and examine address. In place of a scratch-pad word, a small computed constant table can feed the A input. The B operand comes from a single B register through a selector that passes it, shifts it one place, sign-extends its low byte or replaces it with the constant one. The B operand, not the ALU result, is mirrored on a console display output, so the microprogram can show any value it loads into the B register. Advancing the program counter by two uses the constant one on B together with a forced carry-in.

Top module: `mdp_slice`

## Requirements
- R1: While `rst` is high at a rising edge, the B register, `path_data`, `console_lights` and `alu_cout` are cleared to zero at that edge.
- R2: A operand source: `ctl_a_sel`=0 selects scratch-pad word `ctl_a_addr`; `ctl_a_sel`=1 selects constant entry k=`ctl_const_idx`, whose value is 1 shifted left by 2k (1, 4, 16, ..., 16384).
- R3: B operand modes on `ctl_b_mode`: 0 pass the B register, 1 shift left one bit with zero fill, 2 shift right one bit with zero fill, 3 copy bit 7 of the B register into bits 15:8 and keep bits 7:0, 4 constant one; codes 5 to 7 act as pass.
- R4: ALU functions on `ctl_alu_op`: 0 A+B+carry_in, 1 A-B, 2 AND, 3 OR, 4 XOR, 5 pass A, 6 pass B, 7 pass A. `carry_in` affects only code 0; `alu_cout` is the carry out of code 0 and zero for all others.
- R5: `ctl_res_sel`=0 puts the ALU result on the main path; `ctl_res_sel`=1 puts `bus_data` on it regardless of the ALU.
- R6: When `ctl_spad_we` is high at an edge, the main-path value is written to scratch-pad word `ctl_spad_waddr` and is readable from the next cycle; all 16 words hold independent values.
- R7: When `ctl_breg_we` is high at an edge the B register captures the main-path value; when it is low the B register keeps its value.
- R8: `console_lights` shows, one edge later, the B operand of the cycle before, in every B mode.
- R9: A-source word 7, B mode constant one, ALU add with `carry_in`=1 yields the program counter plus two (modulo 2^16, with `alu_cout` set on wrap); written back to word 7 it advances the counter by two each cycle.
- R10: `path_data` and `alu_cout` are registered: they show, after an edge, the result of the control word and state present just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ctl_a_sel | input | 1 | A source: 0 scratch pad, 1 constant table |
| ctl_a_addr | input | 4 | Scratch-pad read address |
| ctl_const_idx | input | 3 | Constant table index |
| ctl_b_mode | input | 3 | B operand selector mode |
| ctl_alu_op | input | 3 | ALU function |
| ctl_res_sel | input | 1 | Main path source: 0 ALU, 1 external bus |
| ctl_spad_we | input | 1 | Scratch-pad write enable |
| ctl_spad_waddr | input | 4 | Scratch-pad write address |
| ctl_breg_we | input | 1 | B register write enable |
| carry_in | input | 1 | Carry into the least significant ALU bit |
| bus_data | input | 16 | Data lines from the external bus |
| path_data | output | 16 | Registered main-path value |
| console_lights | output | 16 | Registered copy of the B operand |
| alu_cout | output | 1 | Registered ALU carry out |

## Verification
Every output is one register past the combinational path, so a control word applied in a cycle shows on `path_data`, `alu_cout` and `console_lights` right after the next rising edge, and the bench samples one nanosecond after that edge. Writes to the scratch pad and B register land at the same edge, so a value written in one cycle is checked through a read in the following cycle, whose result is sampled one edge later again. The console shows the B operand computed from the B register as it was before the edge, so a B register load is seen on the console two edges after the load word is applied. The sweep covers all scratch-pad words, all constants, every B mode over several patterns, and every ALU function with both carry-in values.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

  typedef enum logic [2:0] {
    BM_PASS  = 3'd0,
    BM_SHL   = 3'd1,
    BM_SHR   = 3'd2,
    BM_SEXT  = 3'd3,
    BM_ONE   = 3'd4
  } bmode_e;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_XOR   = 3'd4,
    OP_PASSA = 3'd5,
    OP_PASSB = 3'd6,
    OP_PASSA2 = 3'd7
  } aluop_e;

  localparam logic ASRC_SPAD  = 1'b0;
  localparam logic ASRC_CONST = 1'b1;
  localparam logic RES_ALU    = 1'b0;
  localparam logic RES_BUS    = 1'b1;

endpackage

// File: rtl/mdp_spad.sv
module mdp_spad #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  // Distributed-RAM style: synchronous write, asynchronous read.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/mdp_const_rom.sv
module mdp_const_rom #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic [IW-1:0]     idx,
  output logic [DATA_W-1:0] value
);

  logic [DATA_W-1:0] table_w [DEPTH];

  // Entry k holds a single one at bit position 2k (wrapped to the width).
  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam int POS = (2 * k) % DATA_W;
    assign table_w[k] = {{(DATA_W-1){1'b0}}, 1'b1} << POS;
  end

  assign value = table_w[idx];

endmodule

// File: rtl/mdp_bleg.sv
module mdp_bleg
  import mdp_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int SEXT_BIT = 7
) (
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] breg,
  output logic [DATA_W-1:0] operand
);

  always_comb begin
    unique case (bmode_e'(mode))
      BM_SHL:  operand = {breg[DATA_W-2:0], 1'b0};
      BM_SHR:  operand = {1'b0, breg[DATA_W-1:1]};
      BM_SEXT: operand = {{(DATA_W-SEXT_BIT-1){breg[SEXT_BIT]}}, breg[SEXT_BIT:0]};
      BM_ONE:  operand = {{(DATA_W-1){1'b0}}, 1'b1};
      default: operand = breg;
    endcase
  end

endmodule

// File: rtl/mdp_alu.sv
module mdp_alu
  import mdp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] y,
  output logic              cout
);

  logic [DATA_W:0] sum;

  always_comb begin
    sum = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    cout = 1'b0;
    unique case (aluop_e'(op))
      OP_ADD: begin
        y    = sum[DATA_W-1:0];
        cout = sum[DATA_W];
      end
      OP_SUB:   y = a - b;
      OP_AND:   y = a & b;
      OP_OR:    y = a | b;
      OP_XOR:   y = a ^ b;
      OP_PASSB: y = b;
      default:  y = a;
    endcase
  end

  // R4: carry out only comes from the add function
  always_comb begin
    if (aluop_e'(op) != OP_ADD) assert_cout_add_only_R4: assert (cout == 1'b0);
  end

endmodule

// File: rtl/mdp_slice.sv
module mdp_slice
  import mdp_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SPAD_DEPTH = 16,
  parameter int CONST_DEPTH = 8,
  parameter int PC_LOC     = 7,
  localparam int AW = $clog2(SPAD_DEPTH),
  localparam int CW = $clog2(CONST_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_a_sel,
  input  logic [AW-1:0]     ctl_a_addr,
  input  logic [CW-1:0]     ctl_const_idx,
  input  logic [2:0]        ctl_b_mode,
  input  logic [2:0]        ctl_alu_op,
  input  logic              ctl_res_sel,
  input  logic              ctl_spad_we,
  input  logic [AW-1:0]     ctl_spad_waddr,
  input  logic              ctl_breg_we,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] bus_data,
  output logic [DATA_W-1:0] path_data,
  output logic [DATA_W-1:0] console_lights,
  output logic              alu_cout
);

  logic [DATA_W-1:0] spad_rd;
  logic [DATA_W-1:0] const_val;
  logic [DATA_W-1:0] a_operand;
  logic [DATA_W-1:0] b_operand;
  logic [DATA_W-1:0] breg_q;
  logic [DATA_W-1:0] alu_y;
  logic              alu_c;
  logic [DATA_W-1:0] result;

  logic [DATA_W-1:0] path_q;
  logic [DATA_W-1:0] console_q;
  logic              cout_q;

  mdp_spad #(.DATA_W(DATA_W), .DEPTH(SPAD_DEPTH)) spad_i (
    .clk   (clk),
    .we    (ctl_spad_we & ~rst),
    .waddr (ctl_spad_waddr),
    .wdata (result),
    .raddr (ctl_a_addr),
    .rdata (spad_rd)
  );

  mdp_const_rom #(.DATA_W(DATA_W), .DEPTH(CONST_DEPTH)) rom_i (
    .idx   (ctl_const_idx),
    .value (const_val)
  );

  assign a_operand = (ctl_a_sel == ASRC_CONST) ? const_val : spad_rd;

  mdp_bleg #(.DATA_W(DATA_W)) bleg_i (
    .mode    (ctl_b_mode),
    .breg    (breg_q),
    .operand (b_operand)
  );

  mdp_alu #(.DATA_W(DATA_W)) alu_i (
    .op   (ctl_alu_op),
    .a    (a_operand),
    .b    (b_operand),
    .cin  (carry_in),
    .y    (alu_y),
    .cout (alu_c)
  );

  assign result = (ctl_res_sel == RES_BUS) ? bus_data : alu_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      breg_q    <= '0;
      path_q    <= '0;
      console_q <= '0;
      cout_q    <= 1'b0;
    end else begin
      if (ctl_breg_we) breg_q <= result;
      path_q    <= result;
      console_q <= b_operand;
      cout_q    <= alu_c;
    end
  end

  assign path_data      = path_q;
  assign console_lights = console_q;
  assign alu_cout       = cout_q;

  // R1: reset clears every registered output
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (path_data == '0 && console_lights == '0 && alu_cout == 1'b0));

  // R8: in pass mode the console shows the B register of the previous cycle
  assert_console_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (bmode_e'(ctl_b_mode) == BM_PASS) |=> console_lights == $past(breg_q));

  // R5: bus selection overrides the ALU
  assert_bus_select_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_res_sel == RES_BUS) |=> path_data == $past(bus_data));

  // R9: program counter advance by two
  assert_pc_step_R9: assert property (@(posedge clk) disable iff (rst)
    (ctl_a_sel == ASRC_SPAD && ctl_a_addr == AW'(PC_LOC) &&
     bmode_e'(ctl_b_mode) == BM_ONE && aluop_e'(ctl_alu_op) == OP_ADD &&
     carry_in && ctl_res_sel == RES_ALU)
    |=> path_data == DATA_W'($past(spad_rd) + DATA_W'(2)));

  // R6: a scratch-pad write is visible on the A input the next cycle
  assert_spad_writeback_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_spad_we && !$past(rst)) |=>
      ((ctl_a_sel == ASRC_SPAD && ctl_a_addr == $past(ctl_spad_waddr))
        -> a_operand == $past(result)));

  // R7: B register holds when not written
  assert_breg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!ctl_breg_we && !$past(rst)) |=> breg_q == $past(breg_q));

endmodule

// File: tb/mdp_slice_tb.sv
module mdp_slice_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        ctl_a_sel;
  logic [3:0]  ctl_a_addr;
  logic [2:0]  ctl_const_idx;
  logic [2:0]  ctl_b_mode;
  logic [2:0]  ctl_alu_op;
  logic        ctl_res_sel;
  logic        ctl_spad_we;
  logic [3:0]  ctl_spad_waddr;
  logic        ctl_breg_we;
  logic        carry_in;
  logic [15:0] bus_data;
  logic [15:0] path_data;
  logic [15:0] console_lights;
  logic        alu_cout;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [15:0] spad_model [16];

  always #2 clk = ~clk;

  mdp_slice dut_i (
    .clk(clk), .rst(rst), .ctl_a_sel(ctl_a_sel), .ctl_a_addr(ctl_a_addr),
    .ctl_const_idx(ctl_const_idx), .ctl_b_mode(ctl_b_mode), .ctl_alu_op(ctl_alu_op),
    .ctl_res_sel(ctl_res_sel), .ctl_spad_we(ctl_spad_we), .ctl_spad_waddr(ctl_spad_waddr),
    .ctl_breg_we(ctl_breg_we), .carry_in(carry_in), .bus_data(bus_data),
    .path_data(path_data), .console_lights(console_lights), .alu_cout(alu_cout)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ctl_a_sel = 1'b0; ctl_a_addr = '0; ctl_const_idx = '0; ctl_b_mode = 3'd0;
    ctl_alu_op = 3'd5; ctl_res_sel = 1'b0; ctl_spad_we = 1'b0; ctl_spad_waddr = '0;
    ctl_breg_we = 1'b0; carry_in = 1'b0; bus_data = '0;
  endtask

  task automatic wr_spad(input int addr, input logic [15:0] val);
    idle();
    ctl_res_sel = 1'b1; bus_data = val; ctl_spad_we = 1'b1; ctl_spad_waddr = 4'(addr);
    tick();
    spad_model[addr] = val;
    idle();
  endtask

  task automatic ld_b(input logic [15:0] val);
    idle();
    ctl_res_sel = 1'b1; bus_data = val; ctl_breg_we = 1'b1;
    tick();
    idle();
  endtask

  function automatic logic [16:0] alu_ref(input int op, input logic [15:0] a,
                                           input logic [15:0] b, input logic c);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b} + {16'd0, c};
    case (op)
      0: return s;
      1: return {1'b0, a - b};
      2: return {1'b0, a & b};
      3: return {1'b0, a | b};
      4: return {1'b0, a ^ b};
      6: return {1'b0, b};
      default: return {1'b0, a};
    endcase
  endfunction

  function automatic logic [15:0] bmode_ref(input int m, input logic [15:0] b);
    case (m)
      1: return {b[14:0], 1'b0};
      2: return {1'b0, b[15:1]};
      3: return {{8{b[7]}}, b[7:0]};
      4: return 16'h0001;
      default: return b;
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] bpat [6];
    logic [16:0] r;
    bpat[0] = 16'h80F1; bpat[1] = 16'h7F02; bpat[2] = 16'hFFFF;
    bpat[3] = 16'h0001; bpat[4] = 16'h1234; bpat[5] = 16'h0000;

    idle();
    rst = 1'b1;
    bus_data = 16'hBEEF; ctl_res_sel = 1'b1; ctl_breg_we = 1'b1; ctl_b_mode = 3'd4;
    tick(); tick();
    // R1: cleared despite active controls
    chk("R1 path", path_data, 16'h0000);
    chk("R1 console", console_lights, 16'h0000);
    chk("R1 cout", {15'd0, alu_cout}, 16'h0000);
    rst = 1'b0;
    idle();
    tick();
    chk("R1 breg cleared", console_lights, 16'h0000);

    // R6 / R2: fill and read back every scratch-pad word
    for (int i = 0; i < 16; i++) wr_spad(i, 16'(i * 16'h1111) ^ 16'hA5C3);
    for (int i = 0; i < 16; i++) begin
      idle(); ctl_a_addr = 4'(i);
      tick();
      chk($sformatf("R6 R2 spad word %0d", i), path_data, spad_model[i]);
    end

    // R2: constant table
    for (int k = 0; k < 8; k++) begin
      idle(); ctl_a_sel = 1'b1; ctl_const_idx = 3'(k); ctl_a_addr = 4'd3;
      tick();
      chk($sformatf("R2 const %0d", k), path_data, 16'(1) << (2 * k));
    end

    // R3 / R8 / R7: B modes through the console and through the ALU
    for (int p = 0; p < 6; p++) begin
      ld_b(bpat[p]);
      for (int m = 0; m < 8; m++) begin
        idle(); ctl_b_mode = 3'(m); ctl_alu_op = 3'd6;
        tick();
        chk($sformatf("R8 R3 console mode %0d", m), console_lights, bmode_ref(m, bpat[p]));
        chk($sformatf("R3 alu mode %0d", m), path_data, bmode_ref(m, bpat[p]));
      end
      // R7: no write leaves the B register unchanged
      idle(); ctl_res_sel = 1'b1; bus_data = ~bpat[p];
      tick();
      idle();
      tick();
      chk("R7 breg hold", console_lights, bpat[p]);
    end

    // R4 / R10: ALU sweep over all functions and carry-in values
    for (int p = 0; p < 6; p++) begin
      ld_b(bpat[p]);
      for (int i = 0; i < 16; i++)
        for (int op = 0; op < 8; op++)
          for (int c = 0; c < 2; c++) begin
            idle(); ctl_a_addr = 4'(i); ctl_alu_op = 3'(op); carry_in = c[0];
            tick();
            r = alu_ref(op, spad_model[i], bpat[p], c[0]);
            chk($sformatf("R4 R10 op %0d", op), path_data, r[15:0]);
            chk($sformatf("R4 cout op %0d", op), {15'd0, alu_cout}, {15'd0, r[16]});
          end
    end

    // R5: bus overrides a busy ALU
    ld_b(16'h00FF);
    idle(); ctl_alu_op = 3'd0; ctl_a_addr = 4'd9; ctl_res_sel = 1'b1; bus_data = 16'h5A5A;
    tick();
    chk("R5 bus select", path_data, 16'h5A5A);
    chk("R5 cout still ALU", {15'd0, alu_cout}, {15'd0, alu_ref(0, spad_model[9], 16'h00FF, 1'b0) >> 16});

    // R9: program counter steps by two
    wr_spad(7, 16'h0100);
    for (int s = 1; s <= 3; s++) begin
      idle(); ctl_a_addr = 4'd7; ctl_b_mode = 3'd4; ctl_alu_op = 3'd0; carry_in = 1'b1;
      ctl_spad_we = 1'b1; ctl_spad_waddr = 4'd7;
      tick();
      chk("R9 pc step", path_data, 16'h0100 + 16'(2 * s));
    end
    idle(); ctl_a_addr = 4'd7;
    tick();
    chk("R9 pc stored", path_data, 16'h0106);
    wr_spad(7, 16'hFFFE);
    idle(); ctl_a_addr = 4'd7; ctl_b_mode = 3'd4; ctl_alu_op = 3'd0; carry_in = 1'b1;
    tick();
    chk("R9 pc wrap", path_data, 16'h0000);
    chk("R9 pc wrap cout", {15'd0, alu_cout}, 16'h0001);
    // R6: temporary word 15 untouched by the PC writes
    idle(); ctl_a_addr = 4'd15;
    tick();
    chk("R6 word 15 kept", path_data, spad_model[15]);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule